// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Unit

This block holds the interrupt logic for one general-purpose input port of eight pins. Each pin is first synchronised to the core clock. A per-pin polarity bit then selects whether a rising or a falling transition sets that pin's pending flag. The flags are masked with a per-pin enable mask. The lowest-numbered pin that is both pending and enabled is turned into a vector number, which software reads to find the pin to service.

The block sends a single request toward the interrupt controller. This request is a one-cycle pulse, not a level. It fires when the masked flags go from none set to some set. It also fires when a vector access clears one source and another enabled source is still pending. Because the request is a pulse, an enabled flag that later loses its enable has already produced its request, and an interrupt taken after that finds a vector of 0.

Software reaches the polarity, flag, enable and vector registers through a small single-cycle register port. Any access to the vector register, read or write, acknowledges the source it names.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the polarity, flag and enable registers read 0, the vector reads 0 and `irq_o` is low.
- R2: With polarity bit 0, a low-to-high change on a pin sets that pin's flag on the third rising clock edge after the change. A static level never sets a flag.
- R3: With polarity bit 1, a high-to-low change sets the flag instead, and a low-to-high change on that pin is ignored.
- R4: A write to the flag register (address 1) loads the written value, so software can set a flag. A flag set this way with its enable bit set raises a request.
- R5: Reading address 3 returns 2×(i+1) for the lowest-numbered pin i whose flag and enable bits are both 1, or 0 when there is no such pin. Flags whose enable bit is 0 have no effect on this value.
- R6: Any read or write at address 3 clears only the flag of the pin that the vector names. When the vector is 0, the access changes no flag.
- R7: `irq_o` goes high for exactly one cycle when the OR over all (flag AND enable) bits changes from 0 to 1. It is high in the cycle that follows the clock edge that made the change.
- R8: Setting an enable bit (address 2) while its flag is already set, with no other enabled flag pending, produces a request pulse.
- R9: A vector access that clears one source while another enabled flag is still pending produces a request pulse. An access that leaves nothing pending produces none.
- R10: When a detected edge and a software write that clears the same flag take effect on the same clock edge, the flag ends up set.
- R11: Register reads return data in the same cycle as the access. Addresses: 0 is the polarity register, 1 the flag register, 2 the enable register and 3 the vector register. A register write takes effect at the clock edge that ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | N_PINS | Asynchronous port pin levels |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data, valid in the cycle of the access |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
Each result has a fixed latency. A pin change reaches its flag on the third clock edge, so the bench drives the pin on a falling clock edge and reads the flags after two edges, when the flag must still be 0, and again after the third. Read data is taken inside the access cycle, one time step after the strobe is driven. The request pulse and any write or vector clear are examined at the falling edge right after the clock edge that ends the access. One more idle cycle then confirms that the pulse has dropped. The same-edge contest between a detected edge and a software clear is arranged by starting the clearing write two cycles after the pin change, so that it lands on the third clock edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register select; the vector register position is decoded for its side effect.
    typedef enum logic [1:0] {
        REG_POLARITY = 2'd0,
        REG_FLAGS    = 2'd1,
        REG_ENABLES  = 2'd2,
        REG_VECTOR   = 2'd3
    } reg_sel_e;

    // Decoded register access for one cycle.
    typedef struct packed {
        logic wr_pol;
        logic wr_flag;
        logic wr_en;
        logic vec_touch;
    } acc_dec_t;

    // Vector number reported for pin index idx.
    function automatic int unsigned vec_code(input int unsigned idx);
        return 2 * (idx + 1);
    endfunction

    // Width needed to hold the largest vector number.
    function automatic int unsigned vec_width(input int unsigned pins);
        return $clog2(vec_code(pins - 1) + 1);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
            last_q   <= '0;
        end else begin
            meta_q   <= pins_i;
            stable_q <= meta_q;
            last_q   <= stable_q;
        end
    end

    assign level_o = stable_q;
    assign prev_o  = last_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] fall_sel_i,
    output logic [W-1:0] hit_o
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise;
        logic fall;
        assign rise     = level_i[i] & ~prev_i[i];
        assign fall     = ~level_i[i] & prev_i[i];
        assign hit_o[i] = fall_sel_i[i] ? fall : rise;
    end
endmodule

// File: rtl/gpio_prio_enc.sv
module gpio_prio_enc
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned VW = 5
) (
    input  logic [W-1:0]  req_i,
    output logic [W-1:0]  grant_o,
    output logic [VW-1:0] vec_o
);
    // Scan from the top down so the lowest index is the last to win.
    always_comb begin
        grant_o = '0;
        vec_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                vec_o      = VW'(vec_code(i));
            end
        end
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pins_i,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int unsigned VEC_W = vec_width(N_PINS);

    logic [N_PINS-1:0] pol_q, flag_q, en_q;
    logic [N_PINS-1:0] pol_d, flag_d, en_d;
    logic [N_PINS-1:0] level, prev, edge_hit;
    logic [N_PINS-1:0] masked, grant;
    logic [VEC_W-1:0]  vec;
    logic              irq_q, irq_d;
    logic              pend_now, pend_nxt;
    acc_dec_t          acc;
    reg_sel_e          sel;

    gpio_pin_sync #(.W(N_PINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pins_i  (pins_i),
        .level_o (level),
        .prev_o  (prev)
    );

    gpio_edge_detect #(.W(N_PINS)) u_edge (
        .level_i    (level),
        .prev_i     (prev),
        .fall_sel_i (pol_q),
        .hit_o      (edge_hit)
    );

    assign masked = flag_q & en_q;

    gpio_prio_enc #(.W(N_PINS), .VW(VEC_W)) u_prio (
        .req_i   (masked),
        .grant_o (grant),
        .vec_o   (vec)
    );

    // Access decode.
    always_comb begin
        sel           = reg_sel_e'(bus_addr);
        acc.wr_pol    = bus_en && bus_we && (sel == REG_POLARITY);
        acc.wr_flag   = bus_en && bus_we && (sel == REG_FLAGS);
        acc.wr_en     = bus_en && bus_we && (sel == REG_ENABLES);
        acc.vec_touch = bus_en && (sel == REG_VECTOR);
    end

    // Next state: a detected edge overrides any clear in the same cycle.
    always_comb begin
        pol_d  = acc.wr_pol  ? bus_wdata : pol_q;
        en_d   = acc.wr_en   ? bus_wdata : en_q;
        flag_d = acc.wr_flag ? bus_wdata : flag_q;
        if (acc.vec_touch) begin
            flag_d = flag_d & ~grant;
        end
        flag_d   = flag_d | edge_hit;
        pend_now = |masked;
        pend_nxt = |(flag_d & en_d);
        irq_d    = (pend_nxt && !pend_now) ||
                   (acc.vec_touch && (|grant) && pend_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= '0;
            flag_q <= '0;
            en_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            pol_q  <= pol_d;
            flag_q <= flag_d;
            en_q   <= en_d;
            irq_q  <= irq_d;
        end
    end

    // Read mux, combinational in the access cycle.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_POLARITY: bus_rdata = pol_q;
            REG_FLAGS:    bus_rdata = flag_q;
            REG_ENABLES:  bus_rdata = en_q;
            REG_VECTOR:   bus_rdata[VEC_W-1:0] = vec;
            default:      bus_rdata = '0;
        endcase
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned VEC_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [N_PINS-1:0] flag_q,
    input logic [N_PINS-1:0] en_q,
    input logic [N_PINS-1:0] edge_hit,
    input logic [N_PINS-1:0] grant,
    input logic [VEC_W-1:0]  vec,
    input logic              vec_touch,
    input logic              irq_o
);
    // R5: vector numbers are always even.
    p_vec_even_r5: assert property (@(posedge clk) disable iff (rst)
        vec[0] == 1'b0);

    // R5: no enabled pending flag means a zero vector.
    p_idle_vec_zero_r5: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & en_q) == '0) |-> (vec == '0));

    // R2: a detected edge leaves its flag set on the next cycle.
    p_edge_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

    // R6: a vector access clears the named flag unless an edge hits it.
    p_vec_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_touch && (|grant) && !(|(grant & edge_hit)))
        |=> ((flag_q & $past(grant)) == '0));

    // R7: a rise of the masked OR is accompanied by a request.
    p_rise_pulses_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(|(flag_q & en_q)) |-> irq_o);

    // R9: a request is only seen while an enabled source is pending.
    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|(flag_q & en_q)));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
    .N_PINS (N_PINS),
    .VEC_W  (VEC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .edge_hit  (edge_hit),
    .grant     (grant),
    .vec       (vec),
    .vec_touch (acc.vec_touch),
    .irq_o     (irq_o)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pins = '0;
    logic         bus_en = 1'b0;
    logic         bus_we = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_unit #(.N_PINS(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pins_i    (pins),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling clock edge.
    task automatic bus_write(input logic [1:0] a, input logic [N-1:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [N-1:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    function automatic int exp_vec(input logic [N-1:0] m);
        for (int i = N - 1; i >= 0; i--) begin
            if (m[i]) exp_vec = 2 * (i + 1);
        end
        if (m == '0) exp_vec = 0;
    endfunction

    function automatic logic [N-1:0] lowest(input logic [N-1:0] m);
        lowest = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m[i]) begin
                lowest    = '0;
                lowest[i] = 1'b1;
            end
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rd;
        logic [N-1:0] f;
        logic [N-1:0] e;
        logic [N-1:0] m;
        logic [N-1:0] base;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state.
        check("R1 irq", int'(irq), 0);
        bus_read(2'd0, rd); check("R1 polarity", int'(rd), 0);
        bus_read(2'd1, rd); check("R1 flags", int'(rd), 0);
        bus_read(2'd2, rd); check("R1 enables", int'(rd), 0);
        bus_read(2'd3, rd); check("R1 vector", int'(rd), 0);

        // R4 / R7 / R11: software set, one-cycle pulse, readback.
        bus_write(2'd2, 8'hFF);
        check("R11 enables readback", int'(irq), 0);
        bus_write(2'd1, 8'h80);
        check("R4 sw set pulse", int'(irq), 1);
        @(negedge clk);
        check("R7 pulse one cycle", int'(irq), 0);
        bus_read(2'd1, rd); check("R4 flags", int'(rd), 8'h80);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, rd); check("R4 sw clear", int'(rd), 0);

        // R8: enabling a pending flag pulses; disabled flag hides from vector.
        bus_write(2'd2, 8'h00);
        bus_write(2'd1, 8'h10);
        check("R8 no pulse while disabled", int'(irq), 0);
        bus_read(2'd3, rd); check("R5 disabled flag vector", int'(rd), 0);
        bus_read(2'd1, rd); check("R6 zero vector clears nothing", int'(rd), 8'h10);
        bus_write(2'd2, 8'h10);
        check("R8 enable pulse", int'(irq), 1);
        bus_read(2'd3, rd); check("R8 vector", int'(rd), 10);
        check("R9 no pulse when emptied", int'(irq), 0);

        // R9 / R6: retrigger while another source remains; write access clears too.
        bus_write(2'd2, 8'hFF);
        bus_write(2'd1, 8'h05);
        check("R7 pulse", int'(irq), 1);
        bus_read(2'd3, rd); check("R5 vector pin0", int'(rd), 2);
        check("R9 retrigger", int'(irq), 1);
        @(negedge clk);
        check("R9 pulse one cycle", int'(irq), 0);
        bus_write(2'd3, 8'h00);
        check("R9 no pulse at last", int'(irq), 0);
        bus_read(2'd1, rd); check("R6 write access clears", int'(rd), 0);
        bus_write(2'd3, 8'h00);
        bus_read(2'd1, rd); check("R6 idle access", int'(rd), 0);

        // R2 / R3: every pin, both polarities, with latency.
        for (int pol = 0; pol < 2; pol++) begin
            base = (pol == 1) ? 8'hFF : 8'h00;
            bus_write(2'd2, 8'h00);
            bus_write(2'd0, base);
            pins = base;
            repeat (5) @(negedge clk);
            bus_read(2'd1, rd);
            check(pol == 1 ? "R3 wrong edge ignored" : "R2 static low", int'(rd), 0);
            bus_write(2'd2, 8'hFF);
            for (int i = 0; i < N; i++) begin
                pins[i] = ~base[i];
                repeat (2) @(negedge clk);
                bus_read(2'd1, rd);
                check(pol == 1 ? "R3 latency not yet" : "R2 latency not yet", int'(rd), 0);
                check(pol == 1 ? "R3 pulse" : "R2 pulse", int'(irq), 1);
                bus_read(2'd1, rd);
                check(pol == 1 ? "R3 flag" : "R2 flag", int'(rd), 1 << i);
                bus_read(2'd3, rd);
                check("R5 pin vector", int'(rd), 2 * (i + 1));
                pins[i] = base[i];
                repeat (5) @(negedge clk);
                bus_read(2'd1, rd);
                check(pol == 1 ? "R3 rising ignored" : "R2 falling ignored", int'(rd), 0);
            end
        end

        // R10: edge wins over same-edge software clear.
        bus_write(2'd0, 8'h00);
        pins = '0;
        repeat (5) @(negedge clk);
        bus_write(2'd1, 8'h00);
        pins[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, rd); check("R10 edge beats clear", int'(rd), 8'h04);
        bus_write(2'd1, 8'h00);

        // R5 / R6 / R7 / R9: sweep all flag patterns against several masks.
        for (int k = 0; k < 4; k++) begin
            for (int fi = 0; fi < 256; fi++) begin
                f = fi[7:0];
                case (k)
                    0: e = 8'hFF;
                    1: e = 8'h55;
                    2: e = 8'hF0;
                    default: e = 8'(fi * 37 + 11);
                endcase
                m = f & e;
                bus_write(2'd2, 8'h00);
                bus_write(2'd1, f);
                bus_write(2'd2, e);
                check("R7 sweep pulse", int'(irq), int'(m != 0));
                bus_read(2'd3, rd);
                check("R5 sweep vector", int'(rd), exp_vec(m));
                check("R9 sweep retrigger", int'(irq), int'((m & ~lowest(m)) != 0));
                bus_read(2'd1, rd);
                check("R6 sweep clear", int'(rd), int'(f & ~lowest(m)));
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule